// File: doc/BRIEF.md
# Parallel Branch Charge Equalization Controller

This controller manages a set of battery branches wired in parallel. Each branch has a bypass switch. Opening a branch's switch inserts extra series resistance into that branch, which lowers its share of the pack current. The controller works in repeating equalization periods. Each period starts with a measurement window and ends with a hold window. At the last tick of the measurement window it samples the per-branch state-of-charge words, the signed pack current and a programmable spread limit. It then decides on a switch pattern, and that pattern stays fixed until the next decision.

The sign of the pack current sets the direction: positive means charging and negative means discharging. A current inside a small dead-band counts as idle. While discharging, the branch with the least charge is throttled. While charging, the fullest branch is throttled. A branch is throttled only when the spread between the fullest and emptiest branch is larger than the limit; otherwise every switch is closed so the current shares evenly. The controller stops for good in two cases: a branch reaches full charge while charging, or a branch drops below the low floor while discharging. Once stopped, it closes every switch and raises a stop flag.

State-of-charge words are unsigned fixed-point percent, with FULL_SOC as the code for 100 %. The window lengths are given in clock ticks, so a multi-second real period can be shortened for simulation.

Top module: `branch_equalizer`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) closes all switches (sw_on all ones), clears stopped and clears charging. After rst_n goes high, the first decision is taken at the MEAS_TICKS-th rising edge.
- R2: Decisions happen only at the last tick of the measurement window, which recurs every MEAS_TICKS+HOLD_TICKS cycles. Between decisions sw_on, charging and stopped stay constant, whatever the inputs do.
- R3: At a decision, pack_cur >= DEADBAND sets charging to 1 and pack_cur <= -DEADBAND sets it to 0. A current strictly inside the dead-band is idle: charging keeps its value and all switches close.
- R4: When discharging with spread (max SOC minus min SOC) greater than spread_thr, only the lowest-SOC branch's bit of sw_on is 0 (bit i is branch i).
- R5: When charging with spread greater than spread_thr, only the highest-SOC branch's bit of sw_on is 0.
- R6: When spread is less than or equal to spread_thr, all sw_on bits are 1.
- R7: When several branches tie for the extreme SOC, the lowest-indexed one is throttled.
- R8: At a decision, stopped is set and all switches close if the decided mode is charging and some branch SOC >= FULL_SOC, or if the mode is discharging and some branch SOC < LOW_SOC. stopped then stays set until reset.
- R9: throttling is 1 exactly when one sw_on bit is 0. At most one bit is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soc_flat | input | N*SOC_W | Per-branch SOC, branch i at bits [i*SOC_W +: SOC_W] |
| pack_cur | input | CUR_W | Signed pack current, positive = charging |
| spread_thr | input | SOC_W | Spread limit above which a branch is throttled |
| sw_on | output | N | Switch enables, 1 = closed (low resistance) |
| charging | output | 1 | Current mode, 1 = charging |
| throttling | output | 1 | One branch is throttled |
| stopped | output | 1 | Terminal stop reached |

## Verification
The bench goes after the spread boundary, where a spread equal to the limit must leave every switch closed. An off-by-one comparison would throttle there. It checks ties for both extremes: a design that scans with a non-strict compare would pick the highest-indexed branch. It drives currents exactly at the dead-band edge and one code inside it, and a wrong edge would flip the mode or throttle while idle. It also checks the stop floors at exactly full and one code below the low floor, and changes the inputs in the middle of the hold window, where a design that decides every cycle would change the switch pattern early.

// File: rtl/branch_equalizer.sv
module branch_equalizer #(
  parameter int N          = 4,
  parameter int SOC_W      = 10,
  parameter int CUR_W      = 16,
  parameter int FULL_SOC   = 1000,
  parameter int LOW_SOC    = 50,
  parameter int DEADBAND   = 16,
  parameter int MEAS_TICKS = 4,
  parameter int HOLD_TICKS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N*SOC_W-1:0]      soc_flat,
  input  logic signed [CUR_W-1:0] pack_cur,
  input  logic [SOC_W-1:0]        spread_thr,
  output logic [N-1:0]            sw_on,
  output logic                    charging,
  output logic                    throttling,
  output logic                    stopped
);
  localparam int PERIOD = MEAS_TICKS + HOLD_TICKS;
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic signed [CUR_W-1:0] DB = CUR_W'(DEADBAND);

  logic [CW-1:0]    cnt;
  logic [SOC_W-1:0] lo_v, hi_v;
  logic [IW-1:0]    lo_i, hi_i;
  logic             any_full, any_low;

  always_comb begin
    lo_v = soc_flat[SOC_W-1:0];
    hi_v = soc_flat[SOC_W-1:0];
    lo_i = '0;
    hi_i = '0;
    any_full = 1'b0;
    any_low  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (soc_flat[i*SOC_W +: SOC_W] < lo_v) begin
        lo_v = soc_flat[i*SOC_W +: SOC_W];
        lo_i = IW'(i);
      end
      if (soc_flat[i*SOC_W +: SOC_W] > hi_v) begin
        hi_v = soc_flat[i*SOC_W +: SOC_W];
        hi_i = IW'(i);
      end
      if (soc_flat[i*SOC_W +: SOC_W] >= SOC_W'(FULL_SOC)) any_full = 1'b1;
      if (soc_flat[i*SOC_W +: SOC_W] <  SOC_W'(LOW_SOC))  any_low  = 1'b1;
    end
  end

  wire dec     = (cnt == CW'(MEAS_TICKS - 1));
  wire cur_pos = (pack_cur >= DB);
  wire cur_neg = (pack_cur <= -DB);
  wire idle    = !cur_pos && !cur_neg;
  wire mode_nx = cur_pos ? 1'b1 : (cur_neg ? 1'b0 : charging);
  wire halt    = mode_nx ? any_full : any_low;
  wire [IW-1:0] sel = mode_nx ? hi_i : lo_i;
  wire spread_hi = (hi_v - lo_v) > spread_thr;

  logic [N-1:0] pat;
  always_comb begin
    pat = '1;
    if (!idle && spread_hi) pat[sel] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sw_on    <= '1;
      charging <= 1'b0;
      stopped  <= 1'b0;
    end else begin
      cnt <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
      if (dec) begin
        charging <= mode_nx;
        if (stopped || halt) begin
          stopped <= 1'b1;
          sw_on   <= '1;
        end else begin
          sw_on <= pat;
        end
      end
    end
  end

  assign throttling = ~&sw_on;

  // R9
  one_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sw_on) <= 1);
  // R8
  stop_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (&sw_on && !throttling));
  // R8
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> stopped);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |=> ($stable(sw_on) && $stable(charging) && $stable(stopped)));
endmodule

// File: tb/branch_equalizer_tb.sv
module branch_equalizer_tb;
  localparam int N = 4, SW = 10, CWID = 16;
  localparam int FULL = 1000, LOW = 50, DB = 16, MEAS = 4, HOLD = 12;
  localparam int PER = MEAS + HOLD;

  logic clk = 0, rst_n = 0;
  logic [N*SW-1:0] soc_flat = '0;
  logic signed [CWID-1:0] pack_cur = '0;
  logic [SW-1:0] spread_thr = '0;
  logic [N-1:0] sw_on;
  logic charging, throttling, stopped;

  branch_equalizer u_dut (.clk(clk), .rst_n(rst_n), .soc_flat(soc_flat),
    .pack_cur(pack_cur), .spread_thr(spread_thr), .sw_on(sw_on),
    .charging(charging), .throttling(throttling), .stopped(stopped));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string req = "R1";
  int s[N];
  int mcnt = 0, mchg = 0, mstop = 0;
  logic [N-1:0] msw = '1;
  bit started = 0;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mcnt = 0; msw = '1; mchg = 0; mstop = 0;
    end else begin
      if (mcnt == MEAS - 1) begin
        int lo, hi, cur; bit pos, neg, halt;
        lo = 0; hi = 0; halt = 0;
        for (int i = 0; i < N; i++) begin
          if (s[i] < s[lo]) lo = i;
          if (s[i] > s[hi]) hi = i;
        end
        cur = int'(pack_cur);
        pos = cur >= DB; neg = cur <= -DB;
        if (pos) mchg = 1; else if (neg) mchg = 0;
        for (int i = 0; i < N; i++)
          if ((mchg == 1 && s[i] >= FULL) || (mchg == 0 && s[i] < LOW)) halt = 1;
        msw = '1;
        if (mstop != 0 || halt) mstop = 1;
        else if ((pos || neg) && (s[hi] - s[lo] > int'(spread_thr)))
          msw[mchg == 1 ? hi : lo] = 1'b0;
      end
      mcnt = (mcnt + 1) % PER;
    end
  end

  always @(negedge clk) if (started) begin
    logic exp_thr;
    exp_thr = (msw != '1);
    checks++;
    if (sw_on !== msw || charging !== mchg[0] || stopped !== mstop[0] ||
        throttling !== exp_thr) begin
      errors++;
      $display("FAIL %s sw=%b exp %b chg=%b exp %0d stop=%b exp %0d thr=%b exp %b",
               req, sw_on, msw, charging, mchg, stopped, mstop, throttling, exp_thr);
    end
  end

  task automatic set_in(int a, int b, int c, int d, int cur, int thr);
    @(negedge clk);
    s[0] = a; s[1] = b; s[2] = c; s[3] = d;
    soc_flat = {SW'(d), SW'(c), SW'(b), SW'(a)};
    pack_cur = CWID'(cur);
    spread_thr = SW'(thr);
  endtask

  task automatic expect_out(logic [N-1:0] esw, logic estop, string tag);
    @(negedge clk);
    checks++;
    if (sw_on !== esw || stopped !== estop) begin
      errors++;
      $display("FAIL %s sw=%b exp %b stop=%b exp %b", tag, sw_on, esw, stopped, estop);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) s[i] = 0;
    req = "R1";
    set_in(900, 800, 950, 700, -200, 50);
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_out(4'b1111, 1'b0, "R1");
    repeat (2 * PER) @(negedge clk);
    req = "R4";
    expect_out(4'b0111, 1'b0, "R4");
    req = "R5";
    set_in(900, 800, 950, 700, 200, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1011, 1'b0, "R5");
    req = "R6";
    set_in(600, 650, 620, 640, -200, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1111, 1'b0, "R6 spread equal to limit");
    set_in(600, 650, 620, 640, -200, 49);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1110, 1'b0, "R6 spread one above limit");
    req = "R7";
    set_in(500, 400, 400, 600, -200, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1101, 1'b0, "R7 min tie");
    set_in(600, 400, 600, 500, 200, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1110, 1'b0, "R7 max tie");
    req = "R3";
    set_in(600, 400, 600, 500, 15, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1111, 1'b0, "R3 idle");
    set_in(600, 400, 600, 500, -15, 50);
    repeat (2 * PER) @(negedge clk);
    set_in(600, 400, 600, 500, -16, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1101, 1'b0, "R3 edge discharge");
    req = "R2";
    for (int k = 0; k < 12; k++) begin
      set_in(300 + 40 * k, 500, 700 - 30 * k, 450, (k % 2 == 0) ? 200 : -200, 20);
      repeat (5) @(negedge clk);
    end
    req = "R8";
    set_in(700, 1000, 800, 600, 200, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1111, 1'b1, "R8 full while charging");
    set_in(700, 500, 800, 600, -200, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1111, 1'b1, "R8 sticky");
    req = "R1";
    do_reset();
    expect_out(4'b1111, 1'b0, "R1 reset clears stop");
    req = "R8";
    set_in(700, 50, 800, 600, -200, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1101, 1'b0, "R8 at floor no stop");
    set_in(700, 49, 800, 600, -200, 50);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1111, 1'b1, "R8 below floor");
    req = "R9";
    do_reset();
    set_in(100, 900, 500, 500, -300, 10);
    repeat (2 * PER) @(negedge clk);
    expect_out(4'b1110, 1'b0, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule